// File: doc/BRIEF.md
# Delayed Register-Update Queue

This block keeps a short ring of writes to architectural registers that must not land at once. Each queued write carries a target register, a countdown, a data value, a bit selector and a size flag. Every `tick` counts down each waiting entry. When an entry's countdown runs out, its write is applied to a 32 x 64-bit register file held inside the block. The write either sets or clears one bit, or it replaces a 32-bit or 64-bit word.

Entries leave the ring only from the oldest end. A younger entry that expires first still makes its write at expiry. It then sits in its slot, marked finished, until every older entry has left. It is never written again. An overflow flag reports a push that found the ring full. An error flag watches the consistency of the ring pointers. A read port lets the surrounding logic or a bench inspect any register.

Top module: `dq_delay_queue`

## Requirements
- R1: After reset every register reads zero, the ring is empty, and `overflow` and `error` are low.
- R2: An accepted entry with countdown D (D = 0 acts as 1) makes its write on the D-th later `tick`. The new value is visible on `rd_data` right after the clock edge that sampled that tick, and not before.
- R3: A push while 8 entries are held is dropped and never written. `overflow` is high for exactly the one cycle after that push.
- R4: When `push_bsel` is 0..63 and the value is nonzero, the write sets bit `push_bsel` of the target and leaves every other bit unchanged.
- R5: When `push_bsel` is 0..63 and the value is zero, the write clears that bit and leaves every other bit unchanged.
- R6: When `push_bsel` is negative (its bit 6 is 1) and `push_wide` is 1, the write replaces all 64 bits of the target.
- R7: When `push_bsel` is negative and `push_wide` is 0, the write replaces bits 31:0 of the target with value bits 31:0. Bits 63:32 of the target keep their old contents.
- R8: An expired entry that is not the oldest makes its write once and keeps its slot until all older entries have left. Until then it still counts toward fullness.
- R9: Writes that expire on the same tick are applied oldest first, so the youngest write to a register wins.
- R10: When a push and a tick fall in the same cycle, the tick does not count down the new entry. The push is judged against the occupancy at the start of that cycle, so a full ring rejects it even if the tick frees a slot.
- R11: `error` (write pointer differs from read pointer while the count is zero) stays low in every reachable state.
- R12: A tick on an empty ring changes no register and no queue state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Offer a new delayed write this cycle |
| push_dest | input | 5 | Target register index |
| push_delay | input | 4 | Countdown in ticks (0 treated as 1) |
| push_value | input | 64 | Data; for a bit write, nonzero means set |
| push_bsel | input | 7 | Signed bit selector; negative means whole-word write |
| push_wide | input | 1 | Word size for word writes: 1 = 64 bits, 0 = 32 bits |
| tick | input | 1 | Count down every waiting entry |
| rd_addr | input | 5 | Register file read index |
| rd_data | output | 64 | Register contents, combinational from `rd_addr` |
| overflow | output | 1 | One-cycle flag for a rejected push |
| error | output | 1 | Pointer/count inconsistency |

## Verification
A push and a tick can land on the same clock edge. That clash decides whether the new entry loses a count it should not, and whether a slot freed by the tick can take the push. The bench provokes it twice. First, on an empty ring it pushes a countdown-one write together with a tick, then requires the register to stay old for that edge and change only on the following tick. Second, it fills the ring so the oldest entry expires on the very tick that carries a ninth push, then requires the overflow flag and the permanent absence of the ninth write.

// File: rtl/dq_pkg.sv
package dq_pkg;

    localparam int unsigned REG_W  = 64;
    localparam int unsigned HALF_W = REG_W / 2;
    localparam int unsigned NREG   = 32;
    localparam int unsigned ADDR_W = $clog2(NREG);
    localparam int unsigned DLY_W  = 4;
    localparam int unsigned BIT_W  = $clog2(REG_W) + 1;

    typedef struct packed {
        logic                    live;
        logic                    done;
        logic [ADDR_W-1:0]       dest;
        logic [DLY_W-1:0]        delay;
        logic [REG_W-1:0]        value;
        logic [BIT_W-1:0]        bsel;
        logic                    wide;
    } slot_t;

    typedef struct packed {
        logic                    en;
        logic [ADDR_W-1:0]       dest;
        logic [REG_W-1:0]        value;
        logic [BIT_W-1:0]        bsel;
        logic                    wide;
    } wreq_t;

    // Merge one expiring write into the old register contents.
    function automatic logic [REG_W-1:0] merge_write(logic [REG_W-1:0] old, wreq_t w);
        logic [REG_W-1:0] r;
        r = old;
        if (w.bsel[BIT_W-1]) begin
            if (w.wide) r = w.value;
            else        r[HALF_W-1:0] = w.value[HALF_W-1:0];
        end else begin
            r[w.bsel[BIT_W-2:0]] = |w.value;
        end
        return r;
    endfunction

endpackage

// File: rtl/dq_ring.sv
module dq_ring
    import dq_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned PW   = $clog2(SLOTS),
    localparam int unsigned CW   = $clog2(SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_valid,
    input  slot_t                push_slot,
    input  logic                 tick,
    output wreq_t [SLOTS-1:0]    wr,
    output logic                 overflow,
    output logic                 error,
    output logic [CW-1:0]        total,
    output logic [PW-1:0]        in_ptr,
    output logic [PW-1:0]        out_ptr
);

    typedef struct packed {
        slot_t [SLOTS-1:0] slots;
        logic  [PW-1:0]    wp;
        logic  [PW-1:0]    rp;
        logic  [CW-1:0]    cnt;
        logic              ovf;
    } state_t;

    state_t st_q, st_d;

    logic [PW-1:0] head_d;
    logic [PW-1:0] pos_d;
    logic [CW-1:0] freed_d;
    logic [CW-1:0] pushed_d;

    function automatic logic [PW-1:0] step(logic [PW-1:0] p);
        return (p == PW'(SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] wrap_add(logic [PW-1:0] base, int off);
        int t;
        t = int'(base) + off;
        if (t >= int'(SLOTS)) t = t - int'(SLOTS);
        return PW'(t);
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        wr       = '0;
        head_d   = st_q.rp;
        pos_d    = st_q.rp;
        freed_d  = '0;
        pushed_d = '0;

        // Walk the occupied part of the ring, oldest first.
        if (tick) begin
            for (int i = 0; i < int'(SLOTS); i++) begin
                if (i < int'(st_q.cnt)) begin
                    pos_d = wrap_add(st_q.rp, i);
                    if (st_q.slots[pos_d].done) begin
                        if (pos_d == head_d) begin
                            st_d.slots[pos_d] = '0;
                            head_d            = step(head_d);
                            freed_d           = freed_d + 1'b1;
                        end
                    end else if (st_q.slots[pos_d].live) begin
                        if (st_q.slots[pos_d].delay <= DLY_W'(1)) begin
                            wr[i].en    = 1'b1;
                            wr[i].dest  = st_q.slots[pos_d].dest;
                            wr[i].value = st_q.slots[pos_d].value;
                            wr[i].bsel  = st_q.slots[pos_d].bsel;
                            wr[i].wide  = st_q.slots[pos_d].wide;
                            if (pos_d == head_d) begin
                                st_d.slots[pos_d] = '0;
                                head_d            = step(head_d);
                                freed_d           = freed_d + 1'b1;
                            end else begin
                                st_d.slots[pos_d].done  = 1'b1;
                                st_d.slots[pos_d].delay = '0;
                            end
                        end else begin
                            st_d.slots[pos_d].delay = st_q.slots[pos_d].delay - 1'b1;
                        end
                    end
                end
            end
        end
        st_d.rp = head_d;

        // Admission is judged on the occupancy held at the start of the cycle.
        if (push_valid) begin
            if (st_q.cnt == CW'(SLOTS)) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.slots[st_q.wp]      = push_slot;
                st_d.slots[st_q.wp].live = 1'b1;
                st_d.slots[st_q.wp].done = 1'b0;
                st_d.wp                  = step(st_q.wp);
                pushed_d                 = CW'(1);
            end
        end

        st_d.cnt = st_q.cnt - freed_d + pushed_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overflow = st_q.ovf;
    assign error    = (st_q.wp != st_q.rp) && (st_q.cnt == '0);
    assign total    = st_q.cnt;
    assign in_ptr   = st_q.wp;
    assign out_ptr  = st_q.rp;

endmodule

// File: rtl/dq_regfile.sv
module dq_regfile
    import dq_pkg::*;
#(
    parameter int unsigned SLOTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  wreq_t [SLOTS-1:0]    wr,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [REG_W-1:0]     rd_data
);

    logic [NREG-1:0][REG_W-1:0] rf_q, rf_d;

    // Requests arrive in walk order, so later (younger) ones overwrite earlier ones.
    always_comb begin
        rf_d = rf_q;
        for (int i = 0; i < int'(SLOTS); i++) begin
            if (wr[i].en) rf_d[wr[i].dest] = merge_write(rf_d[wr[i].dest], wr[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign rd_data = rf_q[rd_addr];

endmodule

// File: rtl/dq_delay_queue.sv
module dq_delay_queue
    import dq_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned PW   = $clog2(SLOTS),
    localparam int unsigned CW   = $clog2(SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_valid,
    input  logic [ADDR_W-1:0]    push_dest,
    input  logic [DLY_W-1:0]     push_delay,
    input  logic [REG_W-1:0]     push_value,
    input  logic [BIT_W-1:0]     push_bsel,
    input  logic                 push_wide,
    input  logic                 tick,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [REG_W-1:0]     rd_data,
    output logic                 overflow,
    output logic                 error
);

    slot_t             new_slot;
    wreq_t [SLOTS-1:0] wr_walk;
    logic  [CW-1:0]    q_total;
    logic  [PW-1:0]    q_in;
    logic  [PW-1:0]    q_out;

    always_comb begin
        new_slot       = '0;
        new_slot.dest  = push_dest;
        new_slot.delay = push_delay;
        new_slot.value = push_value;
        new_slot.bsel  = push_bsel;
        new_slot.wide  = push_wide;
    end

    dq_ring #(.SLOTS(SLOTS)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_slot  (new_slot),
        .tick       (tick),
        .wr         (wr_walk),
        .overflow   (overflow),
        .error      (error),
        .total      (q_total),
        .in_ptr     (q_in),
        .out_ptr    (q_out)
    );

    dq_regfile #(.SLOTS(SLOTS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_walk),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/dq_delay_queue_chk.sv
module dq_delay_queue_chk #(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned PW   = $clog2(SLOTS),
    localparam int unsigned CW   = $clog2(SLOTS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          tick,
    input logic          overflow,
    input logic          error,
    input logic [CW-1:0] total,
    input logic [PW-1:0] in_ptr,
    input logic [PW-1:0] out_ptr
);

    assert_overflow_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && total == CW'(SLOTS)) |=> overflow);

    assert_overflow_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(push_valid));

    assert_push_counts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !tick && total < CW'(SLOTS)) |=> (total == $past(total) + 1'b1));

    assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_valid && !tick) |=> ($stable(total) && $stable(out_ptr) && $stable(in_ptr)));

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        total <= CW'(SLOTS));

    assert_ring_consistent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(out_ptr) + int'(total)) % int'(SLOTS)) == int'(in_ptr));

    assert_no_error_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !error);

endmodule

bind dq_delay_queue dq_delay_queue_chk #(.SLOTS(SLOTS)) u_dq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .tick       (tick),
    .overflow   (overflow),
    .error      (error),
    .total      (q_total),
    .in_ptr     (q_in),
    .out_ptr    (q_out)
);

// File: tb/test_dq_delay_queue.sv
`timescale 1ns/1ps
module test_dq_delay_queue;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_valid;
    logic [4:0]  push_dest;
    logic [3:0]  push_delay;
    logic [63:0] push_value;
    logic [6:0]  push_bsel;
    logic        push_wide;
    logic        tick;
    logic [4:0]  rd_addr;
    logic [63:0] rd_data;
    logic        overflow;
    logic        error;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    localparam logic [6:0] WORD = 7'h7F;

    typedef struct packed {
        logic [4:0]  dest;
        logic [6:0]  bsel;
        logic        wide;
        logic [63:0] val;
        logic [63:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{5'd3,  WORD,  1'b1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF},
        '{5'd3,  WORD,  1'b0, 64'hFFFF_FFFF_DEAD_BEEF, 64'h0123_4567_DEAD_BEEF},
        '{5'd3,  7'd63, 1'b0, 64'h1,                   64'h8123_4567_DEAD_BEEF},
        '{5'd3,  7'd0,  1'b0, 64'h0,                   64'h8123_4567_DEAD_BEEE},
        '{5'd7,  7'd40, 1'b1, 64'h5,                   64'h0000_0100_0000_0000},
        '{5'd7,  7'd40, 1'b1, 64'h0,                   64'h0000_0000_0000_0000},
        '{5'd31, WORD,  1'b1, 64'hA5A5_5A5A_C3C3_3C3C, 64'hA5A5_5A5A_C3C3_3C3C},
        '{5'd0,  WORD,  1'b0, 64'h0000_0001_0000_0002, 64'h0000_0000_0000_0002}
    };

    dq_delay_queue i_dq_delay_queue (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_dest(push_dest),
        .push_delay(push_delay), .push_value(push_value), .push_bsel(push_bsel),
        .push_wide(push_wide), .tick(tick), .rd_addr(rd_addr), .rd_data(rd_data),
        .overflow(overflow), .error(error)
    );

    always #4 clk = ~clk;

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input logic [4:0] a, input logic [63:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(rd_data === exp, tag, rd_data, exp);
    endtask

    // Drive one cycle from a negedge, return at the next negedge.
    task automatic cyc(input logic pv, input logic [4:0] d, input logic [3:0] dl,
                       input logic [6:0] b, input logic w, input logic [63:0] v, input logic tk);
        push_valid = pv; push_dest = d; push_delay = dl; push_bsel = b;
        push_wide = w; push_value = v; tick = tk;
        @(negedge clk);
        push_valid = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 5'd0, 4'd0, WORD, 1'b1, 64'h0, 1'b1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [63:0] prev;
        rst_n = 1'b0; push_valid = 1'b0; tick = 1'b0; push_dest = '0; push_delay = '0;
        push_value = '0; push_bsel = WORD; push_wide = 1'b1; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 32; a++) chk_reg(5'(a), 64'h0, "R1 register after reset");
        check(overflow === 1'b0, "R1 overflow after reset", {63'h0, overflow}, 64'h0);
        check(error === 1'b0, "R1 error after reset", {63'h0, error}, 64'h0);

        // Vector table: push with countdown 2, then two ticks (R2 timing, R4..R7 write kinds)
        for (int i = 0; i < 8; i++) begin
            rd_addr = VEC[i].dest; #1; prev = rd_data;
            cyc(1'b1, VEC[i].dest, 4'd2, VEC[i].bsel, VEC[i].wide, VEC[i].val, 1'b0);
            ticks(1);
            chk_reg(VEC[i].dest, prev, "R2 not written before countdown ends");
            ticks(1);
            chk_reg(VEC[i].dest, VEC[i].exp, "R4/R5/R6/R7 write result");
        end

        // R12 ticks on an empty ring
        ticks(3);
        chk_reg(5'd3, 64'h8123_4567_DEAD_BEEE, "R12 empty tick leaves register");
        check(overflow === 1'b0, "R12 no overflow", {63'h0, overflow}, 64'h0);

        // R2 countdown zero acts as one
        cyc(1'b1, 5'd16, 4'd0, WORD, 1'b1, 64'h3C, 1'b0);
        ticks(1);
        chk_reg(5'd16, 64'h3C, "R2 zero countdown expires on first tick");

        // R3 / R9: fill eight, ninth is dropped
        for (int k = 0; k < 8; k++) cyc(1'b1, 5'd9, 4'd15, WORD, 1'b1, 64'(k + 1), 1'b0);
        cyc(1'b1, 5'd10, 4'd1, WORD, 1'b1, 64'h99, 1'b0);
        check(overflow === 1'b1, "R3 overflow after push into full ring", {63'h0, overflow}, 64'h1);
        cyc(1'b0, 5'd0, 4'd0, WORD, 1'b1, 64'h0, 1'b0);
        check(overflow === 1'b0, "R3 overflow lasts one cycle", {63'h0, overflow}, 64'h0);
        ticks(14);
        chk_reg(5'd9, 64'h0, "R2 long countdown not yet expired");
        ticks(1);
        chk_reg(5'd9, 64'h8, "R9 youngest same-tick write wins");
        chk_reg(5'd10, 64'h0, "R3 dropped push never written");

        // R8: younger entries expire first but hold their slots
        cyc(1'b1, 5'd1, 4'd6, WORD, 1'b1, 64'hAAAA, 1'b0);
        cyc(1'b1, 5'd5, 4'd1, WORD, 1'b1, 64'h11, 1'b0);
        cyc(1'b1, 5'd5, 4'd2, WORD, 1'b1, 64'h22, 1'b0);
        ticks(1);
        chk_reg(5'd5, 64'h11, "R8 non-head entry writes at expiry");
        ticks(1);
        chk_reg(5'd5, 64'h22, "R8 later entry overwrites");
        ticks(3);
        chk_reg(5'd5, 64'h22, "R8 finished entry not rewritten");
        chk_reg(5'd1, 64'h0, "R8 head still waiting");
        for (int k = 0; k < 5; k++) cyc(1'b1, 5'd20, 4'd15, WORD, 1'b1, 64'h0, 1'b0);
        cyc(1'b1, 5'd21, 4'd1, WORD, 1'b1, 64'h55, 1'b0);
        check(overflow === 1'b1, "R8 finished slots still count toward full", {63'h0, overflow}, 64'h1);
        ticks(1);
        chk_reg(5'd1, 64'hAAAA, "R8 head expires");
        ticks(15);
        chk_reg(5'd21, 64'h0, "R8 rejected push never written");

        // R10: full ring, tick frees the head in the same cycle as a push
        cyc(1'b1, 5'd12, 4'd1, WORD, 1'b1, 64'h5, 1'b0);
        for (int k = 0; k < 7; k++) cyc(1'b1, 5'd13, 4'd3, WORD, 1'b1, 64'(16 + k), 1'b0);
        cyc(1'b1, 5'd14, 4'd1, WORD, 1'b1, 64'h77, 1'b1);
        check(overflow === 1'b1, "R10 push judged on start-of-cycle occupancy", {63'h0, overflow}, 64'h1);
        chk_reg(5'd12, 64'h5, "R10 head write on shared tick");
        ticks(3);
        chk_reg(5'd13, 64'd22, "R9 youngest of group wins");
        chk_reg(5'd14, 64'h0, "R10 rejected push absent");

        // R10: push with tick on empty ring is not counted down
        cyc(1'b1, 5'd15, 4'd1, WORD, 1'b1, 64'hAB, 1'b1);
        chk_reg(5'd15, 64'h0, "R10 new entry not counted by shared tick");
        ticks(1);
        chk_reg(5'd15, 64'hAB, "R10 new entry expires on next tick");

        check(error === 1'b0, "R11 error stays low", {63'h0, error}, 64'h0);
        finish_run();
    end

endmodule